// File: doc/BRIEF.md
# Write-Protected Banked GPIO Register Block

This block is the register file of a general-purpose I/O controller. Pins are grouped in banks of 32, and there are up to eight banks. Software changes output levels only through two write-one registers per bank. One register raises the selected pins and the other lowers them. Software can read back the driven levels and the synchronized pad levels. Each pin has its own control word that picks its direction. The pad output enable follows that choice directly.

Each bank has a lock word with one bit per pin. While a pin's lock bit is set, the block ignores writes to that pin's control word and to its bits in the set and clear registers. The lock word itself changes only when the bus access just before it wrote the correct key value to a separate key address. That key write allows one lock write. After reset every bank is locked, every pin is an input and every output level is low, so software has to unlock pins before it can use them.

The bus is a plain single-cycle 32-bit read/write port. Read data is registered. It is valid in the cycle after the request and stays unchanged until the next read.

Top module: `gpio_guard_regs`

## Requirements
- R1: After reset all lock words read 0xFFFFFFFF, all output levels are 0, all control words read 1 (input), `pad_oe` and `pad_out` are all zero, and `bus_rdata` is 0.
- R2: Writing the set register of bank b (0x040 + 4*b) raises every unlocked pin whose data bit is 1. Bits written 0 are unchanged. `pad_out` follows the stored level whatever the pin's direction.
- R3: Writing the clear register of bank b (0x060 + 4*b) lowers every unlocked pin whose data bit is 1. Bits written 0 are unchanged.
- R4: The control word of pin n sits at 0x100 + 4*n. Bit 0 = 1 makes the pin an input and bit 0 = 0 makes it an output. A read returns that bit in bit 0 and zeros elsewhere. `pad_oe[n]` is the inverse of bit 0.
- R5: A read at 0x000 + 4*b returns the stored output levels of bank b. A read at 0x020 + 4*b returns the pad inputs of bank b after a synchronizer of SYNC_STAGES flops. Pin n is bit n%32 of bank n/32.
- R6: While a pin's lock bit is 1, writes to its control word and its bits in the set and clear registers have no effect. Reads still return current values.
- R7: The lock word of bank b is at 0x500 + 4*b, and a 1 bit locks that pin. A write to it takes effect only when the previous bus access was a write of 0x00A5A501 to the key address 0x520.
- R8: A key write allows exactly one lock write. Any other bus access in between (read or write), or a key write with a different value, cancels it, and the lock write is then ignored. Idle cycles do not cancel it.
- R9: `bus_rdata` updates in the cycle after a read and holds through writes and idle cycles. The following read as 0 and ignore writes: misaligned addresses, unmapped addresses, the set, clear and key registers, and banks at or above NUM_BANKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_BANKS*32 | Pad input levels (asynchronous) |
| pad_out | output | NUM_BANKS*32 | Driven output levels |
| pad_oe | output | NUM_BANKS*32 | Output enable per pin |

## Verification
The bench builds the block with NUM_BANKS = 2 and SYNC_STAGES = 2. With two banks, the addresses of bank 2 fall outside the configured range, so the out-of-range decode is reached: writes there must vanish and reads must return zero. Bank 1 stays locked from reset for the whole table, so it checks that locking in one bank is independent of unlocking in another. The short synchronizer keeps the input-status latency within a few cycles of the pad change.

// File: rtl/gpio_guard_pkg.sv
package gpio_guard_pkg;

    localparam int BANK_W    = 32;
    localparam int MAX_BANKS = 8;
    localparam int ADDR_W    = 12;

    // Address windows; bank b is at base + 4*b
    localparam logic [ADDR_W-1:0] OUT_BASE  = 12'h000;
    localparam logic [ADDR_W-1:0] IN_BASE   = 12'h020;
    localparam logic [ADDR_W-1:0] SET_BASE  = 12'h040;
    localparam logic [ADDR_W-1:0] CLR_BASE  = 12'h060;
    localparam logic [ADDR_W-1:0] CTL_BASE  = 12'h100;
    localparam logic [ADDR_W-1:0] LOCK_BASE = 12'h500;
    localparam logic [ADDR_W-1:0] KEY_ADDR  = 12'h520;

    localparam logic [BANK_W-1:0] KEY_VALUE = 32'h00A5_A501;

    typedef enum logic [2:0] {
        RG_NONE, RG_OUT, RG_IN, RG_SET, RG_CLR, RG_CTL, RG_LOCK, RG_KEY
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [2:0] bank;
        logic [7:0] pin;
    } decode_t;

    typedef struct packed {
        logic [BANK_W-1:0] out;
        logic [BANK_W-1:0] dir;   // 1 = input
        logic [BANK_W-1:0] lock;  // 1 = locked
    } bank_state_t;

endpackage

// File: rtl/gpio_guard_decode.sv
module gpio_guard_decode
    import gpio_guard_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);

    logic [ADDR_W-1:0] ctl_off;

    always_comb begin
        ctl_off    = addr - CTL_BASE;
        dec.region = RG_NONE;
        dec.bank   = addr[4:2];
        dec.pin    = ctl_off[9:2];
        if (addr[1:0] == 2'b00) begin
            if (addr == KEY_ADDR) begin
                dec.region = RG_KEY;
            end else if (addr[11:5] == OUT_BASE[11:5]) begin
                dec.region = RG_OUT;
            end else if (addr[11:5] == IN_BASE[11:5]) begin
                dec.region = RG_IN;
            end else if (addr[11:5] == SET_BASE[11:5]) begin
                dec.region = RG_SET;
            end else if (addr[11:5] == CLR_BASE[11:5]) begin
                dec.region = RG_CLR;
            end else if (addr >= CTL_BASE && addr < LOCK_BASE) begin
                dec.region = RG_CTL;
                dec.bank   = ctl_off[9:7];
            end else if (addr[11:5] == LOCK_BASE[11:5]) begin
                dec.region = RG_LOCK;
            end
        end
        // Banks beyond the configured count are unmapped
        if (dec.region != RG_NONE && dec.region != RG_KEY &&
            int'(dec.bank) >= NUM_BANKS) begin
            dec.region = RG_NONE;
        end
    end

endmodule

// File: rtl/gpio_guard_key.sv
module gpio_guard_key (
    input  logic clk,
    input  logic rst_n,
    input  logic access,   // any bus access this cycle
    input  logic key_hit,  // correct key written this cycle
    output logic armed
);

    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        if (access) armed_d = key_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    assign armed = armed_q;

endmodule

// File: rtl/gpio_guard_sync.sv
module gpio_guard_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_guard_bank.sv
module gpio_guard_bank
    import gpio_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic              ctl_we,
    input  logic              lock_we,
    input  logic [4:0]        ctl_pin,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] out_q,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] lock_q
);

    bank_state_t       st_d, st_q;
    logic [BANK_W-1:0] wmask;

    always_comb begin
        st_d  = st_q;
        wmask = wdata & ~st_q.lock;
        if (set_we) st_d.out = st_q.out | wmask;
        if (clr_we) st_d.out = st_q.out & ~wmask;
        if (ctl_we && !st_q.lock[ctl_pin]) st_d.dir[ctl_pin] = wdata[0];
        if (lock_we) st_d.lock = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.out  <= '0;
            st_q.dir  <= '1;
            st_q.lock <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_q  = st_q.out;
    assign dir_q  = st_q.dir;
    assign lock_q = st_q.lock;

    // R2: a set write raises every unlocked selected pin
    a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((out_q & $past(wdata & ~lock_q)) == $past(wdata & ~lock_q)));

    // R3: a clear write lowers every unlocked selected pin
    a_r3_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((out_q & $past(wdata & ~lock_q)) == '0));

    // R6: locked output bits never move
    a_r6_locked_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we || clr_we) |=> (((out_q ^ $past(out_q)) & $past(lock_q)) == '0));

    // R6: a control write to a locked pin leaves every direction bit alone
    a_r6_locked_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && lock_q[ctl_pin]) |=> $stable(dir_q));

    // R7: the lock word changes only on a granted lock write
    a_r7_lock_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_we |=> $stable(lock_q));

endmodule

// File: rtl/gpio_guard_regs.sv
module gpio_guard_regs
    import gpio_guard_pkg::*;
#(
    parameter  int NUM_BANKS   = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int NPINS       = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    decode_t           dec;
    logic              wr_acc, rd_acc;
    logic              key_hit, key_armed;
    logic [NPINS-1:0]  in_sync;
    logic [NPINS-1:0]  lock_flat;
    logic [BANK_W-1:0] out_w  [NUM_BANKS];
    logic [BANK_W-1:0] dir_w  [NUM_BANKS];
    logic [BANK_W-1:0] lock_w [NUM_BANKS];
    logic [BANK_W-1:0] rd_word;
    logic [BANK_W-1:0] rdata_d, rdata_q;

    assign wr_acc  = bus_en & bus_wr;
    assign rd_acc  = bus_en & ~bus_wr;
    assign key_hit = wr_acc && (dec.region == RG_KEY) && (bus_wdata == KEY_VALUE);

    gpio_guard_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    gpio_guard_key u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .access  (bus_en),
        .key_hit (key_hit),
        .armed   (key_armed)
    );

    gpio_guard_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (in_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (dec.bank == 3'(b));

        gpio_guard_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_we  (wr_acc && sel && dec.region == RG_SET),
            .clr_we  (wr_acc && sel && dec.region == RG_CLR),
            .ctl_we  (wr_acc && sel && dec.region == RG_CTL),
            .lock_we (wr_acc && sel && dec.region == RG_LOCK && key_armed),
            .ctl_pin (dec.pin[4:0]),
            .wdata   (bus_wdata),
            .out_q   (out_w[b]),
            .dir_q   (dir_w[b]),
            .lock_q  (lock_w[b])
        );

        assign pad_out[b*BANK_W +: BANK_W]   = out_w[b];
        assign pad_oe[b*BANK_W +: BANK_W]    = ~dir_w[b];
        assign lock_flat[b*BANK_W +: BANK_W] = lock_w[b];
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.bank == 3'(b)) begin
                case (dec.region)
                    RG_OUT:  rd_word = out_w[b];
                    RG_IN:   rd_word = in_sync[b*BANK_W +: BANK_W];
                    RG_CTL:  rd_word = {{(BANK_W-1){1'b0}}, dir_w[b][dec.pin[4:0]]};
                    RG_LOCK: rd_word = lock_w[b];
                    default: rd_word = '0;
                endcase
            end
        end
        rdata_d = rd_acc ? rd_word : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    // R7: any change of a lock bit needs a lock write made while the key was armed
    a_r7_lock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flat != $past(lock_flat)) |->
            $past(key_armed && wr_acc && dec.region == RG_LOCK));

    // R9: read data holds when no read is requested
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(bus_rdata));

    // R8: the arm flag never survives a non-key access
    a_r8_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && dec.region != RG_KEY) |=> !key_armed);

endmodule

// File: tb/gpio_guard_regs_test.sv
`timescale 1ns/1ps
module gpio_guard_regs_test;

    localparam int NB    = 2;
    localparam int NPINS = NB * 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_en = 1'b0;
    logic             bus_wr = 1'b0;
    logic [11:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NPINS-1:0] pad_in = '0;
    logic [NPINS-1:0] pad_out;
    logic [NPINS-1:0] pad_oe;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    gpio_guard_regs #(.NUM_BANKS(NB), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;  // write data, or expected read data
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h500, 32'hFFFF_FFFF, 4'd1},  // R1 locked at reset
        '{1'b0, 12'h000, 32'h0000_0000, 4'd1},  // R1 outputs low
        '{1'b0, 12'h104, 32'h0000_0001, 4'd1},  // R1 pins are inputs
        '{1'b1, 12'h520, 32'h00A5_A501, 4'd7},  // R7 arm
        '{1'b1, 12'h500, 32'h0000_0000, 4'd7},  // R7 unlock bank 0
        '{1'b0, 12'h500, 32'h0000_0000, 4'd7},
        '{1'b1, 12'h040, 32'h0000_02F0, 4'd2},  // R2 set
        '{1'b0, 12'h000, 32'h0000_02F0, 4'd2},
        '{1'b1, 12'h060, 32'h0000_0030, 4'd3},  // R3 clear
        '{1'b0, 12'h000, 32'h0000_02C0, 4'd3},
        '{1'b1, 12'h104, 32'h0000_0000, 4'd4},  // R4 pin 1 output
        '{1'b0, 12'h104, 32'h0000_0000, 4'd4},
        '{1'b0, 12'h108, 32'h0000_0001, 4'd4},
        '{1'b1, 12'h520, 32'h00A5_A501, 4'd8},  // R8 arm, then read between
        '{1'b0, 12'h500, 32'h0000_0000, 4'd8},
        '{1'b1, 12'h500, 32'hFFFF_FFFF, 4'd8},
        '{1'b0, 12'h500, 32'h0000_0000, 4'd8},
        '{1'b1, 12'h520, 32'h00A5_A502, 4'd8},  // R8 wrong key
        '{1'b1, 12'h500, 32'hFFFF_FFFF, 4'd8},
        '{1'b0, 12'h500, 32'h0000_0000, 4'd8},
        '{1'b1, 12'h520, 32'h00A5_A501, 4'd7},  // R7 lock pins 8..11
        '{1'b1, 12'h500, 32'h0000_0F00, 4'd7},
        '{1'b1, 12'h500, 32'hFFFF_FFFF, 4'd8},  // R8 second write not armed
        '{1'b0, 12'h500, 32'h0000_0F00, 4'd8},
        '{1'b1, 12'h040, 32'h0000_0FFF, 4'd6},  // R6 set skips locked bits
        '{1'b0, 12'h000, 32'h0000_02FF, 4'd6},
        '{1'b1, 12'h120, 32'h0000_0000, 4'd6},  // R6 locked pin 8 control
        '{1'b0, 12'h120, 32'h0000_0001, 4'd6},
        '{1'b1, 12'h060, 32'hFFFF_FFFF, 4'd6},  // R6 clear skips locked bit 9
        '{1'b0, 12'h000, 32'h0000_0200, 4'd6},
        '{1'b1, 12'h044, 32'h0000_00FF, 4'd6},  // R6 bank 1 still locked
        '{1'b0, 12'h004, 32'h0000_0000, 4'd6},
        '{1'b0, 12'h040, 32'h0000_0000, 4'd9},  // R9 write-only reads zero
        '{1'b1, 12'h048, 32'hFFFF_FFFF, 4'd9},  // R9 bank 2 absent
        '{1'b0, 12'h008, 32'h0000_0000, 4'd9},
        '{1'b0, 12'h504, 32'hFFFF_FFFF, 4'd7},
        '{1'b0, 12'h522, 32'h0000_0000, 4'd9}   // R9 misaligned
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_access(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        check("R1 rdata", {32'h0, bus_rdata}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            bus_access(VECS[i].wr, VECS[i].addr, VECS[i].data);
            if (!VECS[i].wr)
                check($sformatf("R%0d vec %0d", VECS[i].req, i),
                      {32'h0, bus_rdata}, {32'h0, VECS[i].data});
        end

        check("R2 pad_out", pad_out, 64'h0000_0000_0000_0200);
        check("R4 pad_oe", pad_oe, 64'h0000_0000_0000_0002);

        // R5: input status after synchronizer
        pad_in = 64'hDEAD_BEEF_1234_5678;
        repeat (4) @(negedge clk);
        bus_access(1'b0, 12'h020, '0);
        check("R5 in bank0", {32'h0, bus_rdata}, 64'h1234_5678);
        bus_access(1'b0, 12'h024, '0);
        check("R5 in bank1", {32'h0, bus_rdata}, 64'hDEAD_BEEF);

        // R9: read data holds across a write
        bus_access(1'b0, 12'h504, '0);
        bus_access(1'b1, 12'h064, 32'h1);
        repeat (2) @(negedge clk);
        check("R9 hold", {32'h0, bus_rdata}, 64'hFFFF_FFFF);

        // R1: reset mid-run restores the reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 re pad_out", pad_out, '0);
        check("R1 re pad_oe", pad_oe, '0);
        check("R1 re rdata", {32'h0, bus_rdata}, 64'h0);
        bus_access(1'b0, 12'h500, '0);
        check("R1 re lock", {32'h0, bus_rdata}, 64'hFFFF_FFFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule